// File: doc/BRIEF.md
# Attenuator Parallel Control and Power-Up Selector

This block drives the 4-bit control word of a binary-weighted step attenuator. The word's binary value is the attenuation in decibels. A mode pin selects the source of the word: either four weighted parallel pins, or a word supplied by a serial-path companion block in the same clock domain. In parallel operation, the latch-enable level sets the behaviour. When it is high the word tracks the pins. When it is low the word is frozen, and a high-to-low transition on latch enable takes a new value.

The pins are asynchronous to the system clock. All of them pass through two-flop synchronizers before any decision uses them, and latch-enable edges are found in the clock domain. The initial word is not a constant. On the first clock after synchronous reset is released, the block chooses a start-up word from three things: the mode pin, the latch-enable level and a power-up select pin. After that first clock, normal mode rules apply. Latch enable is expected to have a pull-up at the pad, so an undriven pin arrives here as high.

Top module: `step_atten_ctrl`

## Requirements
- R1: `atten_word` bit 3 weighs 8 dB, bit 2 weighs 4 dB, bit 1 weighs 2 dB and bit 0 weighs 1 dB. Its unsigned value is the attenuation, so 4'b1111 is 15 dB and 4'b0000 is reference loss.
- R2: After start-up, with `ser_sel` high (synchronized), `atten_word` takes the value of `ser_word` on the next clock edge.
- R3: After start-up, with `ser_sel` low and `le_pin` high, `atten_word` follows `ctl_pins`. A pin change reaches the output on the third clock edge after the change (two synchronizer stages plus the output register).
- R4: With `ser_sel` low and `le_pin` held low, changes on `ctl_pins` leave `atten_word` unchanged.
- R5: A high-then-low pulse on `le_pin` in parallel mode captures the `ctl_pins` value present when latch enable falls. That value is then held after the pins change.
- R6: On the first clock after reset release, with `ser_sel` high, `atten_word` is loaded from `ctl_pins`. This works for any of the 16 values and ignores `ser_word`.
- R7: On the first clock after reset release, with `ser_sel` low and `le_pin` low, `atten_word` becomes 4'b0000 when `pwr_sel` is 0 and 4'b1000 when `pwr_sel` is 1.
- R8: On the first clock after reset release, with `ser_sel` low and `le_pin` high, `atten_word` equals `ctl_pins` and `pwr_sel` has no effect.
- R9: While `rst_n` is low, `atten_word` is 4'b0000 from the first clock edge of reset onward.
- R10: The start-up choice is made only once. After it, a change of `pwr_sel` has no effect on `atten_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_pins | input | 4 | Weighted parallel control pins (asynchronous) |
| ser_sel | input | 1 | Interface select: 0 parallel, 1 serial (asynchronous) |
| le_pin | input | 1 | Latch enable (asynchronous, pulled up at the pad) |
| pwr_sel | input | 1 | Start-up word select for parallel mode with latch enable low (asynchronous) |
| ser_word | input | 4 | Word from the serial companion block, clock-domain synchronous |
| atten_word | output | 4 | Registered attenuation control word |

## Verification
The assertions check these rules on every cycle, in terms of the synchronized inputs:
- the one-cycle forwarding of the serial word;
- transparent following while latch enable is high;
- holding while latch enable stays low;
- capture at a latch-enable fall;
- both branches of the start-up choice;
- that the start-up flag never clears outside reset.

Some behaviour can only be shown by the bench's scenarios, because it involves the asynchronous pins:
- the three-edge pin-to-output latency;
- the start-up word for every pin value and select combination;
- the zero word during reset;
- the proof that `pwr_sel` toggles after start-up and pin wiggles under a low latch enable never reach the output.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int ATT_BITS = 4;

    // Active source for the word once start-up is complete
    typedef enum logic [1:0] {
        M_SERIAL  = 2'd0,
        M_DIRECT  = 2'd1,
        M_HOLD    = 2'd2,
        M_CAPTURE = 2'd3
    } ctl_mode_e;

    typedef struct packed {
        logic [ATT_BITS-1:0] word;
        logic                booted;
        logic                le_prev;
    } atten_state_t;

    localparam atten_state_t ST_RESET = '{word: '0, booted: 1'b0, le_prev: 1'b1};

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // No reset: the chain keeps sampling during reset so start-up sees settled pins
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stage_q[s] <= din;
            end else begin : g_rest
                always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/atten_mode_decode.sv
module atten_mode_decode
    import atten_pkg::*;
(
    input  logic      ser_s,
    input  logic      le_s,
    input  logic      le_prev,
    output ctl_mode_e mode
);
    always_comb begin
        if (ser_s)        mode = M_SERIAL;
        else if (le_s)    mode = M_DIRECT;
        else if (le_prev) mode = M_CAPTURE;
        else              mode = M_HOLD;
    end
endmodule

// File: rtl/atten_boot_word.sv
module atten_boot_word
    import atten_pkg::*;
(
    input  logic                ser_s,
    input  logic                le_s,
    input  logic                pwr_s,
    input  logic [ATT_BITS-1:0] ctl_s,
    output logic [ATT_BITS-1:0] word
);
    // Parallel start-up with latch enable low: select bit picks the MSB-only word
    localparam logic [ATT_BITS-1:0] HI_WORD = {1'b1, {(ATT_BITS-1){1'b0}}};

    always_comb begin
        if (ser_s || le_s) word = ctl_s;
        else if (pwr_s)    word = HI_WORD;
        else               word = '0;
    end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ATT_BITS-1:0] ctl_pins,
    input  logic                ser_sel,
    input  logic                le_pin,
    input  logic                pwr_sel,
    input  logic [ATT_BITS-1:0] ser_word,
    output logic [ATT_BITS-1:0] atten_word
);
    localparam int SYNC_W = ATT_BITS + 3;

    logic [SYNC_W-1:0]   raw_bus;
    logic [SYNC_W-1:0]   sync_bus;
    logic [ATT_BITS-1:0] ctl_s;
    logic                ser_s;
    logic                le_s;
    logic                pwr_s;
    logic [ATT_BITS-1:0] boot_word;
    ctl_mode_e           mode;
    atten_state_t        st_d;
    atten_state_t        st_q;
    logic                booted_q;
    logic                le_prev_q;

    assign raw_bus = {pwr_sel, le_pin, ser_sel, ctl_pins};

    atten_sync #(
        .WIDTH (SYNC_W),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk (clk),
        .din (raw_bus),
        .dout(sync_bus)
    );

    assign ctl_s = sync_bus[ATT_BITS-1:0];
    assign ser_s = sync_bus[ATT_BITS];
    assign le_s  = sync_bus[ATT_BITS+1];
    assign pwr_s = sync_bus[ATT_BITS+2];

    assign booted_q  = st_q.booted;
    assign le_prev_q = st_q.le_prev;

    atten_mode_decode i_dec (
        .ser_s  (ser_s),
        .le_s   (le_s),
        .le_prev(le_prev_q),
        .mode   (mode)
    );

    atten_boot_word i_boot (
        .ser_s(ser_s),
        .le_s (le_s),
        .pwr_s(pwr_s),
        .ctl_s(ctl_s),
        .word (boot_word)
    );

    always_comb begin
        st_d         = st_q;
        st_d.le_prev = le_s;
        if (!st_q.booted) begin
            st_d.word   = boot_word;
            st_d.booted = 1'b1;
        end else begin
            unique case (mode)
                M_SERIAL:  st_d.word = ser_word;
                M_DIRECT:  st_d.word = ctl_s;
                M_CAPTURE: st_d.word = ctl_s;
                M_HOLD:    st_d.word = st_q.word;
                default:   st_d.word = st_q.word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign atten_word = st_q.word;
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk
    import atten_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ATT_BITS-1:0] atten_word,
    input logic [ATT_BITS-1:0] ser_word,
    input logic [ATT_BITS-1:0] ctl_s,
    input logic                ser_s,
    input logic                le_s,
    input logic                pwr_s,
    input logic                le_prev_q,
    input logic                booted_q
);
    // R2
    serial_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (booted_q && ser_s) |=> (atten_word == $past(ser_word)));

    // R3
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (booted_q && !ser_s && le_s) |=> (atten_word == $past(ctl_s)));

    // R4
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (booted_q && !ser_s && !le_s && !le_prev_q) |=> $stable(atten_word));

    // R5
    fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (booted_q && !ser_s && !le_s && le_prev_q) |=> (atten_word == $past(ctl_s)));

    // R7
    boot_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!booted_q && !ser_s && !le_s) |=>
            (atten_word == {$past(pwr_s), {(ATT_BITS-1){1'b0}}}));

    // R6 R8
    boot_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!booted_q && (ser_s || le_s)) |=> (atten_word == $past(ctl_s)));

    // R10
    boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        booted_q |=> booted_q);
endmodule

bind step_atten_ctrl atten_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .atten_word(atten_word),
    .ser_word  (ser_word),
    .ctl_s     (ctl_s),
    .ser_s     (ser_s),
    .le_s      (le_s),
    .pwr_s     (pwr_s),
    .le_prev_q (le_prev_q),
    .booted_q  (booted_q)
);

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ctl_pins = 4'd0;
    logic       ser_sel = 1'b0;
    logic       le_pin = 1'b1;
    logic       pwr_sel = 1'b0;
    logic [3:0] ser_word = 4'd0;
    logic [3:0] atten_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    step_atten_ctrl i_step_atten_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_pins  (ctl_pins),
        .ser_sel   (ser_sel),
        .le_pin    (le_pin),
        .pwr_sel   (pwr_sel),
        .ser_word  (ser_word),
        .atten_word(atten_word)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        total++;
        if (atten_word !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, atten_word, exp);
        end
    endtask

    // Power-up with given pin levels; reset is held long enough to fill the synchronizers
    task automatic boot(input logic s, input logic l, input logic p,
                        input logic [3:0] pins, input logic [3:0] exp, input string req);
        rst_n    = 1'b0;
        ser_sel  = s;
        le_pin   = l;
        pwr_sel  = p;
        ctl_pins = pins;
        ser_word = ~pins;
        tick(4);
        chk("R9 word zero in reset", 4'd0);
        rst_n = 1'b1;
        tick(1);
        chk(req, exp);
    endtask

    initial begin
        tick(2);
        // R6 serial start-up: any pin value, serial word ignored
        for (int v = 0; v < 16; v++) boot(1'b1, 1'b0, v[0], v[3:0], v[3:0], "R6 serial boot");
        // R8 parallel start-up, latch enable high: pins win, select ignored
        for (int v = 0; v < 32; v++) boot(1'b0, 1'b1, v[4], v[3:0], v[3:0], "R8 parallel le-high boot");
        // R7 parallel start-up, latch enable low: select picks 0 or 8 dB
        for (int v = 0; v < 32; v++) begin
            boot(1'b0, 1'b0, v[4], v[3:0], {v[4], 3'b000}, "R7 parallel le-low boot");
            // R10 later select changes and pin changes do nothing
            pwr_sel  = ~v[4];
            ctl_pins = ~v[3:0];
            tick(5);
            chk("R10 select ignored after start-up", {v[4], 3'b000});
        end

        // R3 / R1 direct mode sweep, exact three-edge latency
        boot(1'b0, 1'b1, 1'b0, 4'd0, 4'd0, "R8 parallel le-high boot");
        for (int v = 0; v < 16; v++) begin
            ctl_pins = v[3:0];
            tick(3);
            chk("R3 direct follow", v[3:0]);
        end
        ctl_pins = 4'b1000;
        tick(3);
        chk("R1 MSB alone is 8 dB", 4'd8);
        ctl_pins = 4'b1111;
        tick(3);
        chk("R1 all ones is 15 dB", 4'd15);

        // R4 latched hold while le low
        ctl_pins = 4'd5;
        tick(3);
        le_pin = 1'b0;
        tick(4);
        for (int v = 0; v < 16; v++) begin
            ctl_pins = v[3:0];
            tick(4);
            chk("R4 hold with le low", 4'd5);
        end

        // R5 high-then-low pulse captures pins present at the fall
        for (int v = 0; v < 16; v++) begin
            ctl_pins = v[3:0];
            tick(3);
            le_pin = 1'b1;
            tick(3);
            le_pin = 1'b0;
            tick(3);
            ctl_pins = ~v[3:0];
            tick(4);
            chk("R5 captured on le fall", v[3:0]);
        end

        // R2 serial path forwarding
        ser_sel = 1'b1;
        tick(3);
        for (int v = 0; v < 16; v++) begin
            ser_word = 4'(15 - v);
            ctl_pins = v[3:0];
            tick(1);
            chk("R2 serial follow", 4'(15 - v));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 40000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule